// File: doc/BRIEF.md
# Reverse-Subtract ALU with Rotator and Flag Register

This block is the integer datapath of a small CPU. It is a 32-bit combinational unit that takes two operands, a shift amount and an operation code, and produces a result in the same cycle. Beside it sits a four-bit condition flag register, held outside the general register file. The unit covers adds, reverse subtracts with and without carry, bitwise logic, full-width rotates and shifts, halfword rotates, sign extension, and whole or single-bit access to the flags.

Subtraction is reversed: the first operand is taken from the second. The carry flag is the carry out of the adder, so after a reverse subtract C=1 means no borrow. A reverse subtract with carry folds the stored C in as a not-borrow. When `op_en` is high, the flag register loads the updated flags on the next rising clock edge. The carry input of the carrying forms comes from that stored C.

Top module: `rsa_alu`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) give opa+opb, and code 1 adds the stored C. After the edge, N is result bit 31, Z means a zero result, C is the carry out of bit 31, and V is signed overflow.
- R2: Codes 2 (reverse subtract) and 3 (reverse subtract with carry) give opb−opa, and code 3 also subtracts (1−C). C is set exactly when no borrow occurs, V is signed overflow, and N and Z follow the result.
- R3: Flags are held as N, Z, C, V in bits 3, 2, 1 and 0. `flag_num` uses these same bit numbers.
- R4: Codes 4, 5 and 6 give opa AND, OR and XOR opb. They update N and Z and leave C and V unchanged.
- R5: Code 8 rotates opa right and code 9 rotates it left, across all 32 bits, by `shamt` (0 to 31). N and Z follow the result, and C and V are kept.
- R6: Code 12 rotates opa[15:0] right and code 13 rotates it left, by `shamt` modulo 16. Result bits 31:16 are zero.
- R7: Code 10 shifts opa left and code 11 shifts it logically right, by `shamt`. C takes the last bit shifted out, and a zero amount leaves C unchanged. N and Z follow the result.
- R8: Code 14 sign-extends opa from bit 7 and code 15 from bit 15. N and Z are updated.
- R9: Code 16 returns the flags in result bits 3:0. Code 17 loads the flags from opa[3:0]. Code 17 and the single-flag codes give a zero result.
- R10: Code 18 clears and code 19 sets the one flag selected by `flag_num`, and the other flags are kept.
- R11: The flags read 0 after reset and change only on a clock edge where `op_en` is 1.
- R12: Codes 7 and 20 to 31 give a zero result and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Commit this cycle's flag update |
| op_sel | input | 5 | Operation code |
| opa | input | 32 | First operand (subtrahend, shift source) |
| opb | input | 32 | Second operand (minuend) |
| shamt | input | 5 | Shift or rotate amount |
| flag_num | input | 2 | Flag bit index for clear and set |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered flags {N,Z,C,V} |

## Verification
`result` is purely combinational, so it is due in the same cycle as its inputs. The bench samples it 2 ns after the falling edge on which the inputs were driven. Updated flags appear after exactly one rising edge and are sampled 1 ns after that edge. Each scoreboard item carries both expectations, and the monitor checks each one in its own window. The carrying operations read the C left by the previous operation, so the reference model keeps its own copy of the flags and follows the same commit rule.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FL_V = 0;
  localparam int unsigned FL_C = 1;
  localparam int unsigned FL_Z = 2;
  localparam int unsigned FL_N = 3;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADC   = 5'd1,
    OP_RSB   = 5'd2,
    OP_RSBC  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_ROR   = 5'd8,
    OP_ROL   = 5'd9,
    OP_LSL   = 5'd10,
    OP_LSR   = 5'd11,
    OP_ROR16 = 5'd12,
    OP_ROL16 = 5'd13,
    OP_SXTB  = 5'd14,
    OP_SXTH  = 5'd15,
    OP_RDFL  = 5'd16,
    OP_WRFL  = 5'd17,
    OP_CFL   = 5'd18,
    OP_SFL   = 5'd19
  } alu_op_e;
endpackage

// File: rtl/rsa_arith.sv
module rsa_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rev_sub,
  input  logic         use_cin,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic         c0;

  // Reverse subtract: b + ~a + 1, or b + ~a + C for the carrying form.
  assign x_op = b;
  assign y_op = rev_sub ? ~a : a;
  assign c0   = use_cin ? cin : rev_sub;

  assign {cout, sum} = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, c0};
  assign ovf = (x_op[W-1] == y_op[W-1]) && (sum[W-1] != x_op[W-1]);
endmodule

// File: rtl/rsa_shift.sv
module rsa_shift #(
  parameter int W = 32,
  localparam int AW = $clog2(W),
  localparam int H = W / 2,
  localparam int HAW = $clog2(H)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic [2:0]    mode,
  output logic [W-1:0]  dout,
  output logic          cout,
  output logic          c_upd
);
  logic [2*W-1:0] dbl;
  logic [AW-1:0]  amt_neg;
  logic [W-1:0]   ror_v;
  logic [W-1:0]   rol_v;
  logic [W:0]     lsl_ext;
  logic [W:0]     lsr_ext;
  logic [2*H-1:0] hdbl;
  logic [HAW-1:0] hamt;
  logic [HAW-1:0] hamt_neg;
  logic [H-1:0]   hror_v;
  logic [H-1:0]   hrol_v;

  assign dbl      = {din, din};
  assign amt_neg  = AW'(0) - amt;
  assign ror_v    = W'(dbl >> amt);
  assign rol_v    = W'(dbl >> amt_neg);
  assign lsl_ext  = {1'b0, din} << amt;
  assign lsr_ext  = {din, 1'b0} >> amt;

  assign hdbl     = {din[H-1:0], din[H-1:0]};
  assign hamt     = amt[HAW-1:0];
  assign hamt_neg = HAW'(0) - hamt;
  assign hror_v   = H'(hdbl >> hamt);
  assign hrol_v   = H'(hdbl >> hamt_neg);

  always_comb begin
    dout  = '0;
    cout  = 1'b0;
    c_upd = 1'b0;
    case (mode)
      3'd0: dout = ror_v;
      3'd1: dout = rol_v;
      3'd2: begin
        dout  = lsl_ext[W-1:0];
        cout  = lsl_ext[W];
        c_upd = (amt != '0);
      end
      3'd3: begin
        dout  = lsr_ext[W:1];
        cout  = lsr_ext[0];
        c_upd = (amt != '0);
      end
      3'd4: dout = {{(W-H){1'b0}}, hror_v};
      3'd5: dout = {{(W-H){1'b0}}, hrol_v};
      default: dout = '0;
    endcase
  end
endmodule

// File: rtl/rsa_flagreg.sv
module rsa_flagreg #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);
  logic [FW-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/rsa_alu.sv
module rsa_alu
  import rsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SH_W-1:0]   shamt,
  input  logic [1:0]        flag_num,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags
);
  logic              rst_q1;
  logic              rst_sync_n;
  logic [DATA_W-1:0] sum;
  logic              add_c;
  logic              add_v;
  logic [DATA_W-1:0] sh_out;
  logic              sh_c;
  logic              sh_cupd;
  logic [3:0]        fl_next;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  rsa_arith #(.W(DATA_W)) arith_i (
    .a       (opa),
    .b       (opb),
    .rev_sub (op_sel[1]),
    .use_cin (op_sel[0]),
    .cin     (flags[FL_C]),
    .sum     (sum),
    .cout    (add_c),
    .ovf     (add_v)
  );

  rsa_shift #(.W(DATA_W)) shift_i (
    .din   (opa),
    .amt   (shamt),
    .mode  (op_sel[2:0]),
    .dout  (sh_out),
    .cout  (sh_c),
    .c_upd (sh_cupd)
  );

  always_comb begin
    result  = '0;
    fl_next = flags;
    case (op_sel)
      OP_ADD, OP_ADC, OP_RSB, OP_RSBC: begin
        result        = sum;
        fl_next[FL_C] = add_c;
        fl_next[FL_V] = add_v;
      end
      OP_AND: result = opa & opb;
      OP_OR:  result = opa | opb;
      OP_XOR: result = opa ^ opb;
      OP_ROR, OP_ROL, OP_LSL, OP_LSR, OP_ROR16, OP_ROL16: begin
        result = sh_out;
        if (sh_cupd) fl_next[FL_C] = sh_c;
      end
      OP_SXTB: result = {{(DATA_W-8){opa[7]}}, opa[7:0]};
      OP_SXTH: result = {{(DATA_W-16){opa[15]}}, opa[15:0]};
      OP_RDFL: result = {{(DATA_W-4){1'b0}}, flags};
      OP_WRFL: fl_next = opa[3:0];
      OP_CFL:  fl_next[flag_num] = 1'b0;
      OP_SFL:  fl_next[flag_num] = 1'b1;
      default: result = '0;
    endcase
    if ((op_sel <= OP_SXTH) && (op_sel != 5'd7)) begin
      fl_next[FL_N] = result[DATA_W-1];
      fl_next[FL_Z] = (result == '0);
    end
  end

  rsa_flagreg #(.FW(4)) flagreg_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (op_en),
    .d     (fl_next),
    .q     (flags)
  );
endmodule

// File: rtl/rsa_alu_chk.sv
module rsa_alu_chk #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              op_en,
  input logic [4:0]        op_sel,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [SH_W-1:0]   shamt,
  input logic [1:0]        flag_num,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags
);
  import rsa_pkg::*;

  p_z_arith_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel <= OP_RSBC) |=> (flags[FL_Z] == ($past(result) == '0)));

  p_rsb_noborrow_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel == OP_RSB) |=> (flags[FL_C] == ($past(opb) >= $past(opa))));

  p_logic_keeps_cv_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
      |=> (flags[1:0] == $past(flags[1:0])));

  p_half_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_ROR16 || op_sel == OP_ROL16) |-> (result[DATA_W-1:16] == '0));

  p_zero_shift_keeps_c_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && (op_sel == OP_LSL || op_sel == OP_LSR) && shamt == '0)
      |=> (flags[FL_C] == $past(flags[FL_C])));

  p_write_flags_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel == OP_WRFL) |=> (flags == $past(opa[3:0])));

  p_set_flag_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel == OP_SFL) |=> (flags == ($past(flags) | (4'b0001 << $past(flag_num)))));

  p_clear_flag_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel == OP_CFL) |=> (flags == ($past(flags) & ~(4'b0001 << $past(flag_num)))));

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_en |=> $stable(flags));

  p_undef_zero_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == 5'd7 || op_sel > OP_SFL) |-> (result == '0));

  p_undef_flags_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == 5'd7 || op_sel > OP_SFL) |=> $stable(flags));
endmodule

bind rsa_alu rsa_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_en      (op_en),
  .op_sel     (op_sel),
  .opa        (opa),
  .opb        (opb),
  .shamt      (shamt),
  .flag_num   (flag_num),
  .result     (result),
  .flags      (flags)
);

// File: tb/rsa_alu_tb_top.sv
module rsa_alu_tb_top;
  import rsa_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        op_en;
  logic [4:0]  op_sel;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [4:0]  shamt;
  logic [1:0]  flag_num;
  logic [31:0] result;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_fl;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  fl;
    string       tag;
  } item_t;
  item_t sb_q[$];

  rsa_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
    .opa(opa), .opb(opb), .shamt(shamt), .flag_num(flag_num),
    .result(result), .flags(flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic void model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [4:0] sh, input logic [1:0] fn, input logic [3:0] fi,
                                output logic [31:0] r, output logic [3:0] fo);
    logic [32:0] t;
    int s;
    bit nz;
    r  = 32'h0;
    fo = fi;
    nz = 1'b1;
    case (op)
      5'd0, 5'd1: begin
        t = {1'b0, a} + {1'b0, b} + ((op == 5'd1) ? {32'h0, fi[1]} : 33'h0);
        r = t[31:0];
        fo[1] = t[32];
        fo[0] = (a[31] == b[31]) && (r[31] != a[31]);
      end
      5'd2, 5'd3: begin
        t = {1'b0, b} - {1'b0, a} - ((op == 5'd3) ? {32'h0, ~fi[1]} : 33'h0);
        r = t[31:0];
        fo[1] = ~t[32];
        fo[0] = (a[31] != b[31]) && (r[31] != b[31]);
      end
      5'd4: r = a & b;
      5'd5: r = a | b;
      5'd6: r = a ^ b;
      5'd8: for (int i = 0; i < 32; i++) r[i] = a[(i + sh) % 32];
      5'd9: for (int i = 0; i < 32; i++) r[(i + sh) % 32] = a[i];
      5'd10: begin
        r = a << sh;
        if (sh != 0) fo[1] = a[32 - sh];
      end
      5'd11: begin
        r = a >> sh;
        if (sh != 0) fo[1] = a[sh - 1];
      end
      5'd12: begin
        s = sh % 16;
        for (int i = 0; i < 16; i++) r[i] = a[(i + s) % 16];
      end
      5'd13: begin
        s = sh % 16;
        for (int i = 0; i < 16; i++) r[(i + s) % 16] = a[i];
      end
      5'd14: r = {{24{a[7]}}, a[7:0]};
      5'd15: r = {{16{a[15]}}, a[15:0]};
      default: nz = 1'b0;
    endcase
    if (nz) begin
      fo[3] = r[31];
      fo[2] = (r == 32'h0);
    end
    case (op)
      5'd16: r = {28'h0, fi};
      5'd17: fo = a[3:0];
      5'd18: fo[fn] = 1'b0;
      5'd19: fo[fn] = 1'b1;
      default: ;
    endcase
  endfunction

  task automatic drive(input string tag, input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh, input logic [1:0] fn,
                       input logic en);
    item_t it;
    logic [31:0] r;
    logic [3:0] fo;
    @(negedge clk);
    op_en = en; op_sel = op; opa = a; opb = b; shamt = sh; flag_num = fn;
    model(op, a, b, sh, fn, model_fl, r, fo);
    if (!en) fo = model_fl;
    model_fl = fo;
    it.res = r; it.fl = fo; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result due 2 ns after the driving edge, flags 1 ns after the next rising edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check({it.tag, " result"}, result, it.res);
        @(posedge clk);
        #1;
        check({it.tag, " flags"}, {28'h0, flags}, {28'h0, it.fl});
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_fl = 4'h0;
    rst_n = 1'b0; op_en = 1'b0; op_sel = 5'd7; opa = '0; opb = '0; shamt = '0; flag_num = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2 check("R11 reset flags", {28'h0, flags}, 32'h0);

    drive("R1 add small",       OP_ADD, 32'd1, 32'd2, 5'd0, 2'd0, 1'b1);
    drive("R1 add wrap",        OP_ADD, 32'hFFFF_FFFF, 32'd1, 5'd0, 2'd0, 1'b1);
    drive("R1 add ovf",         OP_ADD, 32'h7FFF_FFFF, 32'd1, 5'd0, 2'd0, 1'b1);
    drive("R10 set C",          OP_SFL, 32'd0, 32'd0, 5'd0, 2'd1, 1'b1);
    drive("R1 adc C=1",         OP_ADC, 32'd5, 32'd6, 5'd0, 2'd0, 1'b1);
    drive("R2 rsb no borrow",   OP_RSB, 32'd3, 32'd10, 5'd0, 2'd0, 1'b1);
    drive("R2 rsb borrow",      OP_RSB, 32'd10, 32'd3, 5'd0, 2'd0, 1'b1);
    drive("R2 rsbc C=0",        OP_RSBC, 32'd3, 32'd10, 5'd0, 2'd0, 1'b1);
    drive("R2 rsbc C=1",        OP_RSBC, 32'd3, 32'd10, 5'd0, 2'd0, 1'b1);
    drive("R2 rsb ovf",         OP_RSB, 32'd1, 32'h8000_0000, 5'd0, 2'd0, 1'b1);
    drive("R9 write flags",     OP_WRFL, 32'h3, 32'd0, 5'd0, 2'd0, 1'b1);
    drive("R4 and keeps CV",    OP_AND, 32'h0000_F0F0, 32'h0000_0FF0, 5'd0, 2'd0, 1'b1);
    drive("R4 or",              OP_OR,  32'h8000_0000, 32'h0000_0001, 5'd0, 2'd0, 1'b1);
    drive("R4 xor zero",        OP_XOR, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 5'd0, 2'd0, 1'b1);
    drive("R5 ror 4",           OP_ROR, 32'h1234_5678, 32'd0, 5'd4, 2'd0, 1'b1);
    drive("R5 rol 8",           OP_ROL, 32'h1234_5678, 32'd0, 5'd8, 2'd0, 1'b1);
    drive("R5 ror 0",           OP_ROR, 32'h8765_4321, 32'd0, 5'd0, 2'd0, 1'b1);
    drive("R5 rol 31",          OP_ROL, 32'h0000_0003, 32'd0, 5'd31, 2'd0, 1'b1);
    drive("R3 clear C",         OP_CFL, 32'd0, 32'd0, 5'd0, 2'd1, 1'b1);
    drive("R7 lsl out 1",       OP_LSL, 32'h8000_0001, 32'd0, 5'd1, 2'd0, 1'b1);
    drive("R7 lsl 0 keeps C",   OP_LSL, 32'h0000_0010, 32'd0, 5'd0, 2'd0, 1'b1);
    drive("R7 lsr out 1",       OP_LSR, 32'h0000_0001, 32'd0, 5'd1, 2'd0, 1'b1);
    drive("R7 lsr 4 out 0",     OP_LSR, 32'hF000_0007, 32'd0, 5'd4, 2'd0, 1'b1);
    drive("R6 ror16 4",         OP_ROR16, 32'hABCD_1234, 32'd0, 5'd4, 2'd0, 1'b1);
    drive("R6 ror16 mod16",     OP_ROR16, 32'hABCD_1234, 32'd0, 5'd20, 2'd0, 1'b1);
    drive("R6 rol16 4",         OP_ROL16, 32'hABCD_1234, 32'd0, 5'd4, 2'd0, 1'b1);
    drive("R8 sxt byte",        OP_SXTB, 32'h1234_5680, 32'd0, 5'd0, 2'd0, 1'b1);
    drive("R8 sxt half",        OP_SXTH, 32'hFFFF_7FFF, 32'd0, 5'd0, 2'd0, 1'b1);
    drive("R10 set V",          OP_SFL, 32'd0, 32'd0, 5'd0, 2'd0, 1'b1);
    drive("R10 set N",          OP_SFL, 32'd0, 32'd0, 5'd0, 2'd3, 1'b1);
    drive("R10 clear Z",        OP_CFL, 32'd0, 32'd0, 5'd0, 2'd2, 1'b1);
    drive("R9 read flags",      OP_RDFL, 32'hFFFF_FFFF, 32'd0, 5'd0, 2'd0, 1'b1);
    drive("R11 idle add",       OP_ADD, 32'hFFFF_FFFF, 32'd1, 5'd0, 2'd0, 1'b0);
    drive("R11 idle sfl",       OP_SFL, 32'd0, 32'd0, 5'd0, 2'd2, 1'b0);
    drive("R12 code 7",         5'd7,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 2'd0, 1'b1);
    drive("R12 code 25",        5'd25, 32'h1234_5678, 32'd9, 5'd3, 2'd1, 1'b1);
    drive("R9 read after",      OP_RDFL, 32'd0, 32'd0, 5'd0, 2'd0, 1'b1);
    @(negedge clk);
    op_en = 1'b0; op_sel = 5'd7;
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule